// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block sits between the PWM comparators and the gate drivers of one synchronous buck phase. Three digital comparator flags describe the PWM pin: above the high threshold, below the low threshold, or inside the mid-level window. The block turns them into two gate enables, one for the high-side switch and one for the low-side switch, and a flag that reports the suspended (tri-state) condition. All delays are counted in cycles of the system clock.

The flags are first decoded into a level. A level that has been accepted is held for a minimum pulse time, so a shorter command is stretched. A sequencing state machine then orders the gates. On a move to low, the high-side gate is held for a propagation delay and then released. The low side waits until a gate-discharge flag confirms that the high side is really off, and then waits a second delay before it turns on. On a move to high, the low side drops at once and the high side follows after a dead time. A mid-level command keeps the present gates for a hold-off time and then turns both off. An active-low input keeps the low side off. An external enable, driven by the undervoltage logic, overrides everything.

States: `S_OFF` (disabled, both off), `S_DEAD` (low side off, dead-time count), `S_HS_ON`, `S_HS_HOLD` (propagation count with the high side still on), `S_HS_DISCH` (high side off, waiting for the discharge flag), `S_LS_DELAY` (second delay), `S_LS_ON`, `S_MID_WAIT` (hold-off count with the gates frozen), `S_TRI` (suspended). Transitions:
- Any state goes to `S_OFF` while the enable is low.
- A high level leads to `S_DEAD` and from there to `S_HS_ON`. It goes directly back to `S_HS_ON` from `S_HS_HOLD`, and from `S_MID_WAIT` when the high side is still on.
- A low level leads from `S_HS_ON` through `S_HS_HOLD`, `S_HS_DISCH` and `S_LS_DELAY` to `S_LS_ON`. From `S_OFF`, `S_DEAD` and `S_TRI` it enters at `S_HS_DISCH`. `S_MID_WAIT` resumes the state that matches the frozen gates.
- A mid level leads to `S_MID_WAIT`, and after the hold-off to `S_TRI`.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: The flags decode with priority above-high (high level), then below-low (low level), then in-window (mid level). With no flag set, the level stays unchanged. A newly accepted level is held for MIN_PULSE cycles. With defaults (MIN_PULSE=4, LS_DLY=2) and the discharge flag held at 1, a one-cycle high pulse from a steady low keeps the low side off for exactly MIN_PULSE+LS_DLY+1 = 7 cycles and never turns the high side on.
- R2: A high level turns the high side on and keeps the low side off, whatever the level of ls_off_n.
- R3: A mid level that lasts HOLDOFF cycles (measured from the cycle after it is accepted) turns both gates off and raises tri_state. A shorter mid excursion leaves the gates unchanged. While tri_state is 1, both gates are off.
- R4: With a low level, ls_off_n=1 allows the low side on. ls_off_n=0 forces the low side off from the next cycle onward, and releasing it restores the low side in the next cycle.
- R5: After a high-to-low change, the high side stays on for PROP_DLY cycles after the state machine reacts. hs_en falls PROP_DLY+2 cycles after the input change.
- R6: The low side does not turn on while hs_gate_low is 0. After hs_gate_low rises, ls_en rises LS_DLY+1 cycles later.
- R7: After a low-to-high change, ls_en falls two cycles after the input change, and hs_en rises DEAD_CYC cycles after ls_en falls.
- R8: hs_en and ls_en are never 1 in the same cycle.
- R9: drv_en=0 forces both gates off from the next cycle and overrides every other input. When enable returns with a high level, hs_en rises DEAD_CYC+1 cycles later.
- R10: During reset and directly after it, hs_en, ls_en and tri_state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_en | input | 1 | External enable; 0 forces both gates off |
| pwm_above_hi | input | 1 | PWM comparator: above the high threshold |
| pwm_below_lo | input | 1 | PWM comparator: below the low threshold |
| pwm_in_window | input | 1 | PWM comparator: inside the mid-level window |
| ls_off_n | input | 1 | Active-low low-side disable |
| hs_gate_low | input | 1 | High-side gate voltage below its off threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| tri_state | output | 1 | Suspended condition after a mid-level hold-off |

## Verification
The dead-time expiry that would turn the high side on and a drop of the external enable can both occur on the same clock edge. The bench provokes this by lowering drv_en on exactly the cycle in which the dead-time count finishes. It passes only if hs_en never rises and both gates stay off. A second overlap places ls_off_n changes while the low side is frozen inside the hold-off window. In that case the disable must still win within one cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_t;

    typedef enum logic [3:0] {
        S_OFF,
        S_DEAD,
        S_HS_ON,
        S_HS_HOLD,
        S_HS_DISCH,
        S_LS_DELAY,
        S_LS_ON,
        S_MID_WAIT,
        S_TRI
    } seq_state_t;

endpackage

// File: rtl/tpg_level_filter.sv
module tpg_level_filter
    import tpg_pkg::*;
#(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_hi,
    input  logic raw_lo,
    input  logic raw_mid,
    output lvl_t lvl
);
    localparam int HW = $clog2(MIN_PULSE + 1);

    logic [HW-1:0] hold_cnt;
    logic          raw_valid;
    lvl_t          raw_lvl;

    // priority decode of the comparator flags
    always_comb begin
        raw_valid = 1'b1;
        raw_lvl   = lvl;
        if (raw_hi)       raw_lvl = LVL_HIGH;
        else if (raw_lo)  raw_lvl = LVL_LOW;
        else if (raw_mid) raw_lvl = LVL_MID;
        else              raw_valid = 1'b0;
    end

    // accepted level is held for MIN_PULSE cycles (stretch)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl      <= LVL_MID;
            hold_cnt <= '0;
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else if (raw_valid && raw_lvl != lvl) begin
            lvl      <= raw_lvl;
            hold_cnt <= HW'(MIN_PULSE - 1);
        end
    end

endmodule

// File: rtl/tpg_dwell_timer.sv
module tpg_dwell_timer #(
    parameter int MAXV = 32,
    localparam int W   = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt != W'(MAXV)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // cnt counts cycles spent in the current state, zero on entry
    assign done = (cnt == limit - 1'b1);

endmodule

// File: rtl/tpg_gate_fsm.sv
module tpg_gate_fsm
    import tpg_pkg::*;
#(
    parameter int PROP_DLY = 3,
    parameter int LS_DLY   = 2,
    parameter int DEAD_CYC = 5,
    parameter int HOLDOFF  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  lvl_t lvl,
    input  logic ls_off_n,
    input  logic hs_gate_low,
    output logic hs_en,
    output logic ls_en,
    output logic tri_state
);
    localparam int M1   = (PROP_DLY > LS_DLY) ? PROP_DLY : LS_DLY;
    localparam int M2   = (DEAD_CYC > HOLDOFF) ? DEAD_CYC : HOLDOFF;
    localparam int MAXV = (M1 > M2) ? M1 : M2;
    localparam int W    = $clog2(MAXV + 1);

    seq_state_t   state, nxt;
    logic [W-1:0] limit;
    logic         done;

    tpg_dwell_timer #(.MAXV(MAXV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nxt != state),
        .limit   (limit),
        .done    (done)
    );

    always_comb begin
        unique case (state)
            S_HS_HOLD:  limit = W'(PROP_DLY);
            S_LS_DELAY: limit = W'(LS_DLY);
            S_DEAD:     limit = W'(DEAD_CYC);
            S_MID_WAIT: limit = W'(HOLDOFF);
            default:    limit = W'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF, S_TRI: begin
                if (lvl == LVL_HIGH)     nxt = S_DEAD;
                else if (lvl == LVL_LOW) nxt = S_HS_DISCH;
                else if (state == S_OFF) nxt = S_MID_WAIT;
            end
            S_DEAD: begin
                if (lvl == LVL_LOW)      nxt = S_HS_DISCH;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
                else if (done)           nxt = S_HS_ON;
            end
            S_HS_ON: begin
                if (lvl == LVL_LOW)      nxt = S_HS_HOLD;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
            end
            S_HS_HOLD: begin
                if (lvl == LVL_HIGH)     nxt = S_HS_ON;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
                else if (done)           nxt = S_HS_DISCH;
            end
            S_HS_DISCH: begin
                if (lvl == LVL_HIGH)     nxt = S_DEAD;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
                else if (hs_gate_low)    nxt = S_LS_DELAY;
            end
            S_LS_DELAY: begin
                if (lvl == LVL_HIGH)     nxt = S_DEAD;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
                else if (done)           nxt = S_LS_ON;
            end
            S_LS_ON: begin
                if (lvl == LVL_HIGH)     nxt = S_DEAD;
                else if (lvl == LVL_MID) nxt = S_MID_WAIT;
            end
            S_MID_WAIT: begin
                if (lvl == LVL_HIGH)     nxt = hs_en ? S_HS_ON : S_DEAD;
                else if (lvl == LVL_LOW) nxt = hs_en ? S_HS_HOLD :
                                               (ls_en ? S_LS_ON : S_HS_DISCH);
                else if (done)           nxt = S_TRI;
            end
            default: nxt = S_OFF;
        endcase
        if (!drv_en) nxt = S_OFF;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_en     <= 1'b0;
            ls_en     <= 1'b0;
            tri_state <= 1'b0;
        end else begin
            hs_en     <= (nxt == S_HS_ON) || (nxt == S_HS_HOLD) ||
                         (nxt == S_MID_WAIT && hs_en);
            ls_en     <= ls_off_n &&
                         ((nxt == S_LS_ON) || (nxt == S_MID_WAIT && ls_en));
            tri_state <= (nxt == S_TRI);
        end
    end

endmodule

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq
    import tpg_pkg::*;
#(
    parameter int MIN_PULSE = 4,
    parameter int PROP_DLY  = 3,
    parameter int LS_DLY    = 2,
    parameter int DEAD_CYC  = 5,
    parameter int HOLDOFF   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic pwm_above_hi,
    input  logic pwm_below_lo,
    input  logic pwm_in_window,
    input  logic ls_off_n,
    input  logic hs_gate_low,
    output logic hs_en,
    output logic ls_en,
    output logic tri_state
);
    lvl_t lvl;

    tpg_level_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_hi  (pwm_above_hi),
        .raw_lo  (pwm_below_lo),
        .raw_mid (pwm_in_window),
        .lvl     (lvl)
    );

    tpg_gate_fsm #(
        .PROP_DLY (PROP_DLY),
        .LS_DLY   (LS_DLY),
        .DEAD_CYC (DEAD_CYC),
        .HOLDOFF  (HOLDOFF)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_en      (drv_en),
        .lvl         (lvl),
        .ls_off_n    (ls_off_n),
        .hs_gate_low (hs_gate_low),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .tri_state   (tri_state)
    );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
    input logic clk,
    input logic rst_n,
    input logic drv_en,
    input logic ls_off_n,
    input logic hs_en,
    input logic ls_en,
    input logic tri_state
);
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    assert_enable_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (!hs_en && !ls_en));

    assert_ls_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_off_n |=> !ls_en);

    assert_tri_gates_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tri_state |-> (!hs_en && !ls_en));

    assert_hs_after_ls_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!ls_en));

    assert_ls_after_hs_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(!hs_en));

endmodule

bind tri_pwm_gate_seq tpg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_en    (drv_en),
    .ls_off_n  (ls_off_n),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .tri_state (tri_state)
);

// File: tb/tri_pwm_gate_seq_tb.sv
module tri_pwm_gate_seq_tb;
    localparam int MIN_PULSE = 4;
    localparam int PROP_DLY  = 3;
    localparam int LS_DLY    = 2;
    localparam int DEAD_CYC  = 5;
    localparam int HOLDOFF   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 1'b1;
    logic p_hi = 1'b0, p_lo = 1'b0, p_mid = 1'b1;
    logic ls_off_n = 1'b1;
    logic hs_gate_low = 1'b1;
    logic hs_en, ls_en, tri_state;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tri_pwm_gate_seq #(
        .MIN_PULSE(MIN_PULSE), .PROP_DLY(PROP_DLY), .LS_DLY(LS_DLY),
        .DEAD_CYC(DEAD_CYC), .HOLDOFF(HOLDOFF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en),
        .pwm_above_hi(p_hi), .pwm_below_lo(p_lo), .pwm_in_window(p_mid),
        .ls_off_n(ls_off_n), .hs_gate_low(hs_gate_low),
        .hs_en(hs_en), .ls_en(ls_en), .tri_state(tri_state)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // 0 = low, 1 = mid, 2 = high
    task automatic set_lvl(input int l);
        p_hi  = (l == 2);
        p_lo  = (l == 0);
        p_mid = (l == 1);
    endtask

    task automatic go_low_steady();
        @(negedge clk);
        set_lvl(0);
        hs_gate_low = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!hs_en && !ls_en && !tri_state, "R10 reset outputs",
              {hs_en, ls_en, tri_state}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!hs_en && !ls_en && !tri_state, "R10 after reset",
              {hs_en, ls_en, tri_state}, 0);
    endtask

    task automatic t_low_on();
        go_low_steady();
        check(ls_en && !hs_en, "R4 low level gives low side on", {hs_en, ls_en}, 1);
    endtask

    task automatic t_dead_time();
        int ls_fall = 0, hs_rise = 0;
        go_low_steady();
        set_lvl(2);
        hs_gate_low = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (!ls_en && ls_fall == 0) ls_fall = i;
            if (hs_en && hs_rise == 0) hs_rise = i;
        end
        check(ls_fall == 2, "R7 ls falls first", ls_fall, 2);
        check(hs_rise - ls_fall == DEAD_CYC, "R7 dead time", hs_rise - ls_fall, DEAD_CYC);
        check(hs_en && !ls_en, "R2 high level gates", {hs_en, ls_en}, 2);
    endtask

    task automatic t_high_to_low();
        int hs_fall = 0, ls_rise = 0;
        set_lvl(0);
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (!hs_en && hs_fall == 0) hs_fall = i;
        end
        check(hs_fall == PROP_DLY + 2, "R5 propagation delay", hs_fall, PROP_DLY + 2);
        check(!ls_en, "R6 ls waits for discharge flag", ls_en, 0);
        hs_gate_low = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (ls_en && ls_rise == 0) ls_rise = i;
        end
        check(ls_rise == LS_DLY + 1, "R6 second delay", ls_rise, LS_DLY + 1);
    endtask

    task automatic t_ls_disable();
        go_low_steady();
        ls_off_n = 1'b0;
        @(negedge clk);
        check(!ls_en, "R4 disable forces ls off", ls_en, 0);
        repeat (5) @(negedge clk);
        check(!ls_en, "R4 ls stays off while disabled", ls_en, 0);
        ls_off_n = 1'b1;
        @(negedge clk);
        check(ls_en, "R4 release restores ls", ls_en, 1);
    endtask

    task automatic t_high_ignores_disable();
        go_low_steady();
        ls_off_n = 1'b0;
        set_lvl(2);
        hs_gate_low = 1'b0;
        repeat (DEAD_CYC + 4) @(negedge clk);
        check(hs_en && !ls_en, "R2 high with ls_off_n low", {hs_en, ls_en}, 2);
        ls_off_n = 1'b1;
        repeat (3) @(negedge clk);
        check(hs_en && !ls_en, "R2 high with ls_off_n high", {hs_en, ls_en}, 2);
    endtask

    task automatic t_stretch();
        int low_cnt = 0, hs_seen = 0;
        go_low_steady();
        set_lvl(2);
        @(negedge clk);
        set_lvl(0);
        low_cnt = ls_en ? 0 : 1;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (!ls_en) low_cnt++;
            if (hs_en) hs_seen = 1;
        end
        check(low_cnt == MIN_PULSE + LS_DLY + 1, "R1 stretched pulse", low_cnt,
              MIN_PULSE + LS_DLY + 1);
        check(hs_seen == 0, "R1 short pulse never reaches hs", hs_seen, 0);
    endtask

    task automatic t_holdoff();
        go_low_steady();
        set_lvl(1);
        repeat (HOLDOFF + 1) @(negedge clk);
        check(ls_en && !tri_state, "R3 gates held during hold-off", {ls_en, tri_state}, 2);
        @(negedge clk);
        check(!ls_en && !hs_en && tri_state, "R3 shutdown after hold-off",
              {hs_en, ls_en, tri_state}, 1);
    endtask

    task automatic t_tri_exit();
        int tri_clr = 0, hs_rise = 0;
        hs_gate_low = 1'b0;
        set_lvl(2);
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            if (!tri_state && tri_clr == 0) tri_clr = i;
            if (hs_en && hs_rise == 0) hs_rise = i;
        end
        check(tri_clr == 2, "R3 tri clears on high", tri_clr, 2);
        check(hs_rise == DEAD_CYC + 2, "R7 hs after tri exit", hs_rise, DEAD_CYC + 2);
    endtask

    task automatic t_short_mid();
        int dropped = 0;
        go_low_steady();
        set_lvl(1);
        repeat (6) @(negedge clk);
        set_lvl(0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!ls_en || tri_state) dropped = 1;
        end
        check(dropped == 0, "R3 short mid excursion ignored", dropped, 0);
    endtask

    task automatic t_enable();
        int hs_rise = 0, any_on = 0;
        set_lvl(2);
        hs_gate_low = 1'b0;
        repeat (DEAD_CYC + 6) @(negedge clk);
        drv_en = 1'b0;
        @(negedge clk);
        check(!hs_en && !ls_en, "R9 disable forces off", {hs_en, ls_en}, 0);
        set_lvl(0);
        hs_gate_low = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (hs_en || ls_en) any_on = 1;
        end
        check(any_on == 0, "R9 low ignored while disabled", any_on, 0);
        set_lvl(2);
        hs_gate_low = 1'b0;
        repeat (MIN_PULSE + 2) @(negedge clk);
        drv_en = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (hs_en && hs_rise == 0) hs_rise = i;
        end
        check(hs_rise == DEAD_CYC + 1, "R9 resume after enable", hs_rise, DEAD_CYC + 1);
    endtask

    task automatic t_collision();
        int hs_seen = 0;
        go_low_steady();
        set_lvl(2);
        hs_gate_low = 1'b0;
        repeat (DEAD_CYC + 1) @(negedge clk);
        drv_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (hs_en || ls_en) hs_seen = 1;
        end
        check(hs_seen == 0, "R9 enable drop on dead-time expiry", hs_seen, 0);
        drv_en = 1'b1;
    endtask

    task automatic t_overlap_scan();
        int both = 0;
        for (int k = 0; k < 12; k++) begin
            set_lvl(k % 3);
            hs_gate_low = (k % 2 == 0);
            for (int i = 0; i < 3 + k; i++) begin
                @(negedge clk);
                if (hs_en && ls_en) both++;
            end
        end
        check(both == 0, "R8 never both gates", both, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_low_on();
        t_dead_time();
        t_high_to_low();
        t_ls_disable();
        t_high_ignores_disable();
        t_stretch();
        t_holdoff();
        t_tri_exit();
        t_short_mid();
        t_enable();
        t_collision();
        t_overlap_scan();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule